// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates eight interrupt sources for an 8-bit controller core. Six of them (external pin 0, timer 0, external pin 1, timer 1, serial port, timer 2) reach it already detected, together with their enable and level-select bits as plain input vectors. The remaining two are raw active-low pins that the block samples, synchronizes and detects itself. Those two pins are configured through one 8-bit control register that software reaches by byte writes at SFR address C0h or by single-bit writes at bit addresses C0h to C7h.

Among pending, enabled requests the block picks one using two software-selected levels and a fixed polling order within each level. It then drives a request line, a level indicator and the entry address of the chosen handler. The core pulses an acknowledge when it starts servicing the request and a return pulse when the handler finishes. The block keeps one in-service bit per level so that a low-level handler can be interrupted by a high-level request but a high-level handler cannot be interrupted at all.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the control register reads 00h, irq_o is 0, vec_o is 00h and no level is in service.
- R2: The control register is written whole by a byte write to address C0h and one bit at a time by a bit write to bit address C0h+n (n = 0..7). Its layout, from bit 0 up, is: pin2 trigger, pin2 flag, pin2 enable, pin2 level, pin3 trigger, pin3 flag, pin3 enable, pin3 level.
- R3: Each pin passes through a two-flop synchronizer. With trigger = 1 (edge mode), a high-then-low sequence in two successive synchronized samples sets the flag; the request is visible three clock edges after the pin falls, not after two, and a pin held low does not set the flag again.
- R4: With trigger = 0 (level mode), the request follows the synchronized pin while it is low, and the flag bit reads as the synchronized pin being low without being latched.
- R5: A pin request reaches arbitration only when its enable bit is 1; with enable 0 an edge still sets the flag.
- R6: A pending high-level request (level bit 1) always wins over every low-level request.
- R7: Within one level the order, highest first, is ext0, timer0, ext1, timer1, serial, timer2, pin2, pin3 (indices 0 to 7).
- R8: vec_o is 8*index + 03h for the chosen source (03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh) and 00h when irq_o is 0.
- R9: ack_i while irq_o is 1 marks the chosen level in service and, for pin2 or pin3 in edge mode, clears that pin's flag.
- R10: While a low-level handler is in service only high-level requests raise irq_o; while a high-level handler is in service irq_o stays 0.
- R11: ret_i clears the high in-service bit if it is set, and otherwise the low one.
- R12: ack_i while irq_o is 0 has no effect on in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 6 | Pending requests of the core-side sources, index 0..5 |
| src_en_i | input | 6 | Enables of the core-side sources |
| src_hi_i | input | 6 | Level select of the core-side sources, 1 = high |
| xpin_ni | input | 2 | Raw active-low pins for sources 6 and 7 |
| sfr_we_i | input | 1 | Byte write strobe |
| sfr_addr_i | input | 8 | Byte write address |
| sfr_wdata_i | input | 8 | Byte write data |
| bit_we_i | input | 1 | Bit write strobe |
| bit_addr_i | input | 8 | Bit write address |
| bit_val_i | input | 1 | Bit write value |
| ack_i | input | 1 | Servicing of the presented request starts |
| ret_i | input | 1 | Current handler has returned |
| ctl_o | output | 8 | Control register read value |
| irq_o | output | 1 | A request is presented |
| irq_hi_o | output | 1 | Presented request is high level |
| vec_o | output | 8 | Handler entry address |

## Verification
The bench aims at the synchronizer latency, since a design with one flop too few raises the pin request a cycle early and one with an extra flop a cycle late. It holds a pin low after servicing to catch a detector that retriggers on level, and releases a level-mode pin to catch a flag that was wrongly latched. It nests a high-level request inside a low-level handler and then returns once, so a controller that clears the wrong in-service bit either stays silent or presents a low request too early. A stray acknowledge with nothing pending must leave a later low request unblocked.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam logic [7:0] VEC_BASE = 8'h03;

  // trig at bit 0 .. level at bit 3, per pin
  typedef struct packed {
    logic hi;
    logic en;
    logic flag;
    logic trig;
  } xpin_cfg_t;

  function automatic logic [7:0] vec_of(input logic [7:0] idx);
    return VEC_BASE + (idx << 3);
  endfunction
endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic low_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign low_o  = ~sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/xctl_reg.sv
module xctl_reg #(
  parameter int         NPIN = 2,
  parameter logic [7:0] BASE = 8'hC0,
  localparam int        W    = 4 * NPIN
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            byte_we_i,
  input  logic [7:0]      addr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            bit_we_i,
  input  logic [7:0]      bit_addr_i,
  input  logic            bit_val_i,
  input  logic [NPIN-1:0] fall_i,
  input  logic [NPIN-1:0] low_i,
  input  logic [NPIN-1:0] svc_i,
  output logic [W-1:0]    rdata_o,
  output logic [NPIN-1:0] req_o,
  output logic [NPIN-1:0] hi_o
);
  import irq_ctl_pkg::*;

  logic [W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (byte_we_i && addr_i == BASE) ctl_d = wdata_i;
    for (int b = 0; b < W; b++)
      if (bit_we_i && bit_addr_i == BASE + 8'(b)) ctl_d[b] = bit_val_i;
    for (int p = 0; p < NPIN; p++) begin
      if (svc_i[p] && ctl_q[4*p])  ctl_d[4*p+1] = 1'b0;
      if (fall_i[p] && ctl_q[4*p]) ctl_d[4*p+1] = 1'b1; // hw set wins
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    xpin_cfg_t cfg, eff;
    assign cfg      = ctl_q[4*p +: 4];
    assign eff.trig = cfg.trig;
    assign eff.flag = cfg.trig ? cfg.flag : low_i[p];
    assign eff.en   = cfg.en;
    assign eff.hi   = cfg.hi;
    assign rdata_o[4*p +: 4] = eff;
    assign req_o[p] = eff.en & eff.flag;
    assign hi_o[p]  = eff.hi;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int  N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  hi_i,
  input  logic          allow_lo_i,
  input  logic          allow_hi_i,
  output logic          valid_o,
  output logic          hi_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    hi_o    = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--)
      if (allow_lo_i && req_i[i] && !hi_i[i]) begin
        valid_o = 1'b1;
        hi_o    = 1'b0;
        idx_o   = IW'(i);
      end
    // high level overrides any low pick
    for (int i = N - 1; i >= 0; i--)
      if (allow_hi_i && req_i[i] && hi_i[i]) begin
        valid_o = 1'b1;
        hi_o    = 1'b1;
        idx_o   = IW'(i);
      end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int         NINT     = 6,
  parameter int         NPIN     = 2,
  parameter int         SYNC_STG = 2,
  parameter logic [7:0] CTL_ADDR = 8'hC0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NINT-1:0] src_req_i,
  input  logic [NINT-1:0] src_en_i,
  input  logic [NINT-1:0] src_hi_i,
  input  logic [NPIN-1:0] xpin_ni,
  input  logic            sfr_we_i,
  input  logic [7:0]      sfr_addr_i,
  input  logic [4*NPIN-1:0] sfr_wdata_i,
  input  logic            bit_we_i,
  input  logic [7:0]      bit_addr_i,
  input  logic            bit_val_i,
  input  logic            ack_i,
  input  logic            ret_i,
  output logic [4*NPIN-1:0] ctl_o,
  output logic            irq_o,
  output logic            irq_hi_o,
  output logic [7:0]      vec_o
);
  import irq_ctl_pkg::*;

  localparam int NSRC = NINT + NPIN;
  localparam int IW   = $clog2(NSRC);

  logic [NPIN-1:0] pin_low, pin_fall, pin_req, pin_hi, pin_svc;
  logic [NSRC-1:0] req_all, hi_all;
  logic [1:0]      ins_q, ins_d;   // [1] high, [0] low in service
  logic            pick_vld, pick_hi, take;
  logic [IW-1:0]   pick_idx;

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    xpin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_ni(xpin_ni[p]),
      .low_o (pin_low[p]),
      .fall_o(pin_fall[p])
    );
    assign pin_svc[p] = take && pick_idx == IW'(NINT + p);
  end

  xctl_reg #(.NPIN(NPIN), .BASE(CTL_ADDR)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_we_i (sfr_we_i),
    .addr_i    (sfr_addr_i),
    .wdata_i   (sfr_wdata_i),
    .bit_we_i  (bit_we_i),
    .bit_addr_i(bit_addr_i),
    .bit_val_i (bit_val_i),
    .fall_i    (pin_fall),
    .low_i     (pin_low),
    .svc_i     (pin_svc),
    .rdata_o   (ctl_o),
    .req_o     (pin_req),
    .hi_o      (pin_hi)
  );

  assign req_all = {pin_req, src_req_i & src_en_i};
  assign hi_all  = {pin_hi, src_hi_i};

  prio_pick #(.N(NSRC)) u_pick (
    .req_i     (req_all),
    .hi_i      (hi_all),
    .allow_lo_i(ins_q == 2'b00),
    .allow_hi_i(!ins_q[1]),
    .valid_o   (pick_vld),
    .hi_o      (pick_hi),
    .idx_o     (pick_idx)
  );

  assign take = pick_vld & ack_i;

  always_comb begin
    ins_d = ins_q;
    if (ret_i) begin
      if (ins_q[1]) ins_d[1] = 1'b0;
      else          ins_d[0] = 1'b0;
    end
    if (take) ins_d[pick_hi] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ins_q <= 2'b00;
    else         ins_q <= ins_d;
  end

  assign irq_o    = pick_vld;
  assign irq_hi_o = pick_vld & pick_hi;
  assign vec_o    = pick_vld ? vec_of(8'(pick_idx)) : 8'h00;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         irq_hi_o,
  input logic [7:0]   vec_o,
  input logic         ack_i,
  input logic [1:0]   ins_q,
  input logic [N-1:0] req_vec,
  input logic [N-1:0] hi_vec
);
  logic [7:0] vidx;
  assign vidx = (vec_o - 8'h03) >> 3;

  AST_VEC_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[2:0] == 3'd3 && vidx < 8'(N)));                          // R8
  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == 8'h00);                                               // R8
  AST_VEC_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(req_vec & (N'(1) << vidx)));                                  // R7
  AST_HI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_hi_o) |-> (req_vec & hi_vec) == '0);                       // R6
  AST_LO_ONLY_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_q[0] && irq_o) |-> irq_hi_o);                                        // R10
  AST_HI_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_q[1] |-> !irq_o);                                                     // R10
  AST_ACK_MARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i && irq_hi_o) |=> ins_q[1]);                               // R9
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N(NSRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .irq_hi_o(irq_hi_o),
  .vec_o   (vec_o),
  .ack_i   (ack_i),
  .ins_q   (ins_q),
  .req_vec (req_all),
  .hi_vec  (hi_all)
);

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] src_req_i = '0, src_en_i = '0, src_hi_i = '0;
  logic [1:0] xpin_ni = 2'b11;
  logic       sfr_we_i = 1'b0, bit_we_i = 1'b0, bit_val_i = 1'b0;
  logic [7:0] sfr_addr_i = '0, sfr_wdata_i = '0, bit_addr_i = '0;
  logic       ack_i = 1'b0, ret_i = 1'b0;
  logic [7:0] ctl_o, vec_o;
  logic       irq_o, irq_hi_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_ctl = '0;
  logic [1:0] m_ins = '0;

  always #4 clk_i = ~clk_i;

  vec_irq_ctrl u_vec_irq_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // expected read value of the control register
  function automatic logic [7:0] exp_ctl(input logic [7:0] c, input logic [1:0] plow);
    logic [7:0] r = c;
    if (!c[0]) r[1] = plow[0];
    if (!c[4]) r[5] = plow[1];
    return r;
  endfunction

  // {valid, hi, vec}
  function automatic logic [9:0] exp_pick(input logic [5:0] rq, input logic [5:0] en,
      input logic [5:0] hi, input logic [7:0] c, input logic [1:0] plow, input logic [1:0] ins);
    logic [7:0] r, h;
    logic [7:0] e;
    e = exp_ctl(c, plow);
    r = {e[6] & e[5], e[2] & e[1], rq & en};
    h = {e[7], e[3], hi};
    if (!ins[1])
      for (int i = 0; i < 8; i++) if (r[i] && h[i]) return {1'b1, 1'b1, 8'(8 * i + 3)};
    if (ins == 2'b00)
      for (int i = 0; i < 8; i++) if (r[i] && !h[i]) return {1'b1, 1'b0, 8'(8 * i + 3)};
    return 10'd0;
  endfunction

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk_i); sfr_we_i = 1'b1; sfr_addr_i = 8'hC0; sfr_wdata_i = d;
    @(negedge clk_i); sfr_we_i = 1'b0; #1;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    @(negedge clk_i); bit_we_i = 1'b1; bit_addr_i = a; bit_val_i = v;
    @(negedge clk_i); bit_we_i = 1'b0; #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk_i); ack_i = 1'b1;
    @(negedge clk_i); ack_i = 1'b0; #1;
  endtask

  task automatic pulse_ret();
    @(negedge clk_i); ret_i = 1'b1;
    @(negedge clk_i); ret_i = 1'b0; #1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic chk_out(input string tag, input logic irq, input logic hi, input logic [7:0] vec);
    chk({tag, " irq"}, irq_o, irq);
    chk({tag, " hi"}, irq_hi_o, hi);
    chk({tag, " vec"}, vec_o, vec);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd7331));
    wait_cyc(2);
    // R1 reset state
    chk("R1 ctl", ctl_o, 8'h00);
    chk_out("R1", 1'b0, 1'b0, 8'h00);
    rst_ni = 1'b1;
    wait_cyc(1);
    chk_out("R1 post", 1'b0, 1'b0, 8'h00);

    // R2/R3 edge mode on pin2
    wr_byte(8'h05);
    chk("R2 byte write", ctl_o, 8'h05);
    @(negedge clk_i); xpin_ni[0] = 1'b0;
    wait_cyc(2);
    chk("R3 two edges no req", irq_o, 1'b0);
    wait_cyc(1);
    chk_out("R3 third edge", 1'b1, 1'b0, 8'h33);
    chk("R3 flag set", ctl_o, 8'h07);
    pulse_ack();
    chk("R9 flag cleared", ctl_o, 8'h05);
    chk("R9 no irq", irq_o, 1'b0);
    wait_cyc(4);
    chk("R3 no retrigger", ctl_o, 8'h05);
    pulse_ret();
    chk("R11 after ret", irq_o, 1'b0);
    @(negedge clk_i); xpin_ni[0] = 1'b1;
    wait_cyc(3);

    // R4 level mode on pin3
    wr_byte(8'h40);
    @(negedge clk_i); xpin_ni[1] = 1'b0;
    wait_cyc(3);
    chk_out("R4 level req", 1'b1, 1'b0, 8'h3B);
    chk("R4 flag follows pin", ctl_o, 8'h60);
    @(negedge clk_i); xpin_ni[1] = 1'b1;
    wait_cyc(3);
    chk_out("R4 released", 1'b0, 1'b0, 8'h00);
    chk("R4 not latched", ctl_o, 8'h40);

    // R5 enable gating, R2 bit write
    wr_byte(8'h01);
    @(negedge clk_i); xpin_ni[0] = 1'b0;
    wait_cyc(4);
    chk("R5 flag latched", ctl_o, 8'h03);
    chk("R5 disabled no irq", irq_o, 1'b0);
    wr_bit(8'hC2, 1'b1);
    chk("R2 bit write", ctl_o, 8'h07);
    chk_out("R5 enabled", 1'b1, 1'b0, 8'h33);
    @(negedge clk_i); xpin_ni[0] = 1'b1;

    // R7 polling order, R6 level
    src_en_i = 6'h3F; src_req_i = 6'b000010; #1;
    chk_out("R7 timer0 over pin2", 1'b1, 1'b0, 8'h0B);
    src_req_i = 6'b100010; src_hi_i = 6'b100000; #1;
    chk_out("R6 timer2 high wins", 1'b1, 1'b1, 8'h2B);
    pulse_ack();
    chk("R10 hi in service", irq_o, 1'b0);
    src_req_i = 6'b100011; src_hi_i = 6'b100001; #1;
    chk("R10 hi not preempted", irq_o, 1'b0);
    pulse_ret();
    chk_out("R11 ret hi then ext0", 1'b1, 1'b1, 8'h03);
    src_hi_i = 6'b000000; #1;
    chk_out("R7 ext0 first", 1'b1, 1'b0, 8'h03);
    pulse_ack();
    chk("R10 lo blocks lo", irq_o, 1'b0);
    src_req_i = 6'b110011; src_hi_i = 6'b010000; #1;
    chk_out("R10 hi preempts lo", 1'b1, 1'b1, 8'h23);
    pulse_ack();
    chk("R10 both in service", irq_o, 1'b0);
    pulse_ret();
    chk_out("R11 hi cleared first", 1'b1, 1'b1, 8'h23);
    src_hi_i = 6'b000000; #1;
    chk("R11 lo still in service", irq_o, 1'b0);
    pulse_ret();
    chk_out("R11 lo cleared", 1'b1, 1'b0, 8'h03);

    // R12 stray ack
    src_req_i = '0;
    wr_byte(8'h00);
    chk("R12 idle", irq_o, 1'b0);
    pulse_ack();
    src_req_i = 6'b001000; #1;
    chk_out("R12 ack ignored", 1'b1, 1'b0, 8'h1B);
    src_req_i = '0;
    m_ctl = 8'h00; m_ins = 2'b00;

    // constrained random, pins idle high
    for (int it = 0; it < 3000; it++) begin
      logic [9:0] e;
      int act;
      @(negedge clk_i);
      sfr_we_i = 1'b0; bit_we_i = 1'b0; ack_i = 1'b0; ret_i = 1'b0;
      src_req_i = 6'($urandom); src_en_i = 6'($urandom); src_hi_i = 6'($urandom);
      #1;
      e = exp_pick(src_req_i, src_en_i, src_hi_i, m_ctl, 2'b00, m_ins);
      chk("R6/R7 rnd irq", irq_o, e[9]);
      chk("R6 rnd hi", irq_hi_o, e[8]);
      chk("R8 rnd vec", vec_o, e[7:0]);
      chk("R2 rnd ctl", ctl_o, exp_ctl(m_ctl, 2'b00));
      act = int'($urandom % 8);
      case (act)
        0: begin sfr_we_i = 1'b1; sfr_addr_i = 8'hC0; sfr_wdata_i = 8'($urandom); end
        1: begin bit_we_i = 1'b1; bit_addr_i = 8'hC0 + 8'($urandom % 8); bit_val_i = 1'($urandom); end
        2, 3, 4: ack_i = 1'b1;
        5: ret_i = 1'b1;
        default: ;
      endcase
      @(posedge clk_i);
      if (sfr_we_i) m_ctl = sfr_wdata_i;
      if (bit_we_i) m_ctl[bit_addr_i[2:0]] = bit_val_i;
      if (ack_i && e[9]) begin
        m_ins[e[8]] = 1'b1;
        if (e[7:0] == 8'h33 && m_ctl[0]) m_ctl[1] = 1'b0;
        if (e[7:0] == 8'h3B && m_ctl[4]) m_ctl[5] = 1'b0;
      end
      if (ret_i) begin
        if (m_ins[1]) m_ins[1] = 1'b0;
        else          m_ins[0] = 1'b0;
      end
    end
    @(negedge clk_i);
    sfr_we_i = 1'b0; bit_we_i = 1'b0; ack_i = 1'b0; ret_i = 1'b0;
    report();
  end
endmodule